// File: doc/BRIEF.md
# Dithered Quadrature Phase Generator

This block produces the phase of a numerically controlled oscillator and turns it into two lookup addresses, one in-phase and one a quarter turn ahead. An N-bit accumulator adds a tuning word on every enabled clock and wraps modulo 2^N. A frequency offset is summed into the tuning word, which gives frequency modulation. A phase offset is summed after the accumulator, which gives phase modulation.

Before the phase is cut down to an M-bit table address, the block can add pseudo-random dither into the lowest N-M+1 bits. The dither comes from a maximal-length shift register and spreads the periodic truncation error. Both channels take the same dither sample, so the two addresses always stay exactly a quarter table apart. The block also has a preset input that forces the accumulator to a chosen starting phase. A sine table placed after the block turns each address into an amplitude.

Top module: `nco_phase_core`

## Requirements
- R1: While rst_n is low, phase_out is 0, addr_i is 0, addr_q is 2^(M-2), and the dither register holds its seed (default 32'hACE1_2468).
- R2: On each rising edge with en high and preset_en low, the accumulator becomes accumulator + fcw + freq_off modulo 2^N, and the carry is lost. phase_out is the accumulator register itself.
- R3: With en low and preset_en low, phase_out, addr_i, addr_q and the dither register keep their values.
- R4: On a rising edge with preset_en high, the accumulator takes preset_val, whatever the value of en. The addresses and the dither register still follow en.
- R5: On an enabled edge, addr_i becomes bits [N-1:N-M] of (accumulator + phase_off + dither). All values used are those from before the edge, and the sum is modulo 2^N.
- R6: On an enabled edge, addr_q becomes bits [N-1:N-M] of (accumulator + phase_off + 2^(N-2) + dither), using the same dither value as addr_i. addr_q - addr_i modulo 2^M is always 2^(M-2).
- R7: The dither is the low N-M+1 bits of a 32-bit right-shifting register, zero-extended. On each enabled edge, if bit 0 is 1 the register becomes (s>>1) XOR 32'h8020_0003, and otherwise it becomes s>>1. The register never reaches zero.
- R8: With dither_en low, the dither added is zero, so the addresses are the plain truncation of the phase sum. The dither register still steps on each enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the accumulator, the dither and the addresses |
| fcw | input | N | Tuning word added on every enabled clock |
| freq_off | input | N | Frequency offset summed with the tuning word |
| phase_off | input | N | Phase offset added after the accumulator |
| dither_en | input | 1 | Enables dither ahead of truncation |
| preset_en | input | 1 | Loads preset_val into the accumulator |
| preset_val | input | N | Starting phase for the preset |
| phase_out | output | N | Accumulator register |
| addr_i | output | M | In-phase table address |
| addr_q | output | M | Quadrature table address |

## Verification
A wrong accumulator value shows on phase_out at the very next edge. It reaches both addresses one edge later, because they sample the accumulator from before each edge. A wrong dither state does not show on phase_out. It shows only as address values that differ from a truncation with dither when dither_en is high, and it persists until reset because the register never resynchronises. The bench runs a per-edge model of the accumulator, the dither register and both addresses. It therefore catches any such error within one or two clocks of its cause, and separately checks the fixed quarter-table gap between addr_q and addr_i.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned DTH_REG_W = 32;
  // x^32 + x^22 + x^2 + x + 1, right-shifting Galois form
  localparam logic [DTH_REG_W-1:0] DTH_TAPS = 32'h8020_0003;

  function automatic logic [DTH_REG_W-1:0] dth_step(input logic [DTH_REG_W-1:0] s);
    logic [DTH_REG_W-1:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ DTH_TAPS;
    return r;
  endfunction
endpackage

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             preset_en,
  input  logic [ACC_W-1:0] preset_val,
  input  logic [ACC_W-1:0] fcw,
  input  logic [ACC_W-1:0] freq_off,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] step_w;
  logic [ACC_W-1:0] acc_nx;

  always_comb begin
    step_w = fcw + freq_off;
    acc_nx = acc;
    if (preset_en) acc_nx = preset_val;
    else if (en)   acc_nx = acc + step_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_nx;
  end

  a_r2_wrap_add: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !preset_en) |=> acc == ACC_W'($past(acc) + $past(fcw) + $past(freq_off)));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !preset_en) |=> $stable(acc));
  a_r4_preset: assert property (@(posedge clk) disable iff (!rst_n)
    preset_en |=> acc == $past(preset_val));
endmodule

// File: rtl/nco_dither_lfsr.sv
module nco_dither_lfsr
  import nco_pkg::*;
#(
  parameter int unsigned           DITH_W = 21,
  parameter logic [DTH_REG_W-1:0]  SEED   = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dither_en,
  output logic [DITH_W-1:0] dither
);
  logic [DTH_REG_W-1:0] st;
  logic [DTH_REG_W-1:0] st_nx;

  always_comb begin
    st_nx = st;
    if (en) st_nx = dth_step(st);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SEED;
    else        st <= st_nx;
  end

  assign dither = dither_en ? st[DITH_W-1:0] : '0;

  a_r7_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0);
  a_r7_moves: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> st != $past(st));
  a_r3_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(st));
endmodule

// File: rtl/nco_addr_chan.sv
module nco_addr_chan #(
  parameter int unsigned            ACC_W     = 32,
  parameter int unsigned            ADDR_W    = 12,
  parameter int unsigned            DITH_W    = 21,
  parameter logic [ACC_W-1:0]       CH_OFFSET = '0,
  parameter logic [ADDR_W-1:0]      RST_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ACC_W-1:0]  acc,
  input  logic [ACC_W-1:0]  phase_off,
  input  logic [DITH_W-1:0] dither,
  output logic [ADDR_W-1:0] addr
);
  logic [ACC_W-1:0]  sum_w;
  logic [ADDR_W-1:0] addr_nx;

  always_comb begin
    sum_w   = acc + phase_off + CH_OFFSET + ACC_W'(dither);
    addr_nx = addr;
    if (en) addr_nx = sum_w[ACC_W-1 -: ADDR_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= RST_ADDR;
    else        addr <= addr_nx;
  end

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(addr));
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [31:0] SEED   = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ACC_W-1:0]  fcw,
  input  logic [ACC_W-1:0]  freq_off,
  input  logic [ACC_W-1:0]  phase_off,
  input  logic              dither_en,
  input  logic              preset_en,
  input  logic [ACC_W-1:0]  preset_val,
  output logic [ACC_W-1:0]  phase_out,
  output logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int unsigned TRUNC_W = ACC_W - ADDR_W;
  localparam int unsigned DITH_W  = TRUNC_W + 1;
  localparam logic [ADDR_W-1:0] QTR_ADDR = ADDR_W'(1) << (ADDR_W - 2);

  logic [ACC_W-1:0]  acc;
  logic [DITH_W-1:0] dither;
  logic [ADDR_W-1:0] addr_ch [2];

  nco_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(en),
    .preset_en(preset_en), .preset_val(preset_val),
    .fcw(fcw), .freq_off(freq_off), .acc(acc)
  );

  nco_dither_lfsr #(.DITH_W(DITH_W), .SEED(SEED)) u_dth (
    .clk(clk), .rst_n(rst_n), .en(en),
    .dither_en(dither_en), .dither(dither)
  );

  for (genvar c = 0; c < 2; c++) begin : g_chan
    localparam logic [ACC_W-1:0]  OFF = (c == 0) ? '0 : (ACC_W'(1) << (ACC_W - 2));
    localparam logic [ADDR_W-1:0] RST = (c == 0) ? '0 : QTR_ADDR;
    nco_addr_chan #(
      .ACC_W(ACC_W), .ADDR_W(ADDR_W), .DITH_W(DITH_W),
      .CH_OFFSET(OFF), .RST_ADDR(RST)
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .en(en),
      .acc(acc), .phase_off(phase_off), .dither(dither),
      .addr(addr_ch[c])
    );
  end

  assign phase_out = acc;
  assign addr_i    = addr_ch[0];
  assign addr_q    = addr_ch[1];

  logic [ADDR_W-1:0] quad_gap;
  assign quad_gap = addr_q - addr_i;

  a_r6_quarter_gap: assert property (@(posedge clk) disable iff (!rst_n)
    quad_gap == QTR_ADDR);
  a_r8_no_dither_truncation: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dither_en && phase_off == '0) |=> addr_i == $past(acc[ACC_W-1 -: ADDR_W]));
endmodule

// File: tb/sim_nco_phase_core.sv
module sim_nco_phase_core;
  localparam int PERIOD = 10;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam logic [31:0] SEED = 32'hACE1_2468;
  localparam logic [31:0] DMASK = 32'h001F_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [31:0] fcw = '0, freq_off = '0, phase_off = '0, preset_val = '0;
  logic dither_en = 1'b0, preset_en = 1'b0;
  logic [31:0] phase_out;
  logic [11:0] addr_i, addr_q;

  int errors = 0;
  int checks = 0;
  bit chk_on = 0;
  string tag = "R2";

  bit [31:0] m_acc, m_lfsr, d;
  bit [11:0] m_ai, m_aq;

  always #(PERIOD/2) clk = ~clk;

  nco_phase_core u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .fcw(fcw), .freq_off(freq_off),
    .phase_off(phase_off), .dither_en(dither_en), .preset_en(preset_en),
    .preset_val(preset_val), .phase_out(phase_out), .addr_i(addr_i), .addr_q(addr_q)
  );

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_ai = 0; m_aq = 12'd1024; m_lfsr = SEED;
    end else begin
      d = dither_en ? (m_lfsr & DMASK) : 32'd0;
      if (en) begin
        m_ai = 12'((m_acc + phase_off + d) >> 20);
        m_aq = 12'((m_acc + phase_off + 32'h4000_0000 + d) >> 20);
        m_lfsr = m_lfsr[0] ? ((m_lfsr >> 1) ^ TAPS) : (m_lfsr >> 1);
      end
      if (preset_en) m_acc = preset_val;
      else if (en)   m_acc = m_acc + fcw + freq_off;
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    check({tag, " phase_out"}, phase_out, m_acc);
    check({tag, " addr_i R5"}, 32'(addr_i), 32'(m_ai));
    check({tag, " addr_q R6"}, 32'(addr_q), 32'(m_aq));
    check("R6 quarter gap", 32'(12'(addr_q - addr_i)), 32'd1024);
  end

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rec;
    cyc(3);
    tag = "R1";
    check("R1 reset phase_out", phase_out, 32'd0);
    check("R1 reset addr_i", 32'(addr_i), 32'd0);
    check("R1 reset addr_q", 32'(addr_q), 32'd1024);
    rst_n = 1'b1;
    chk_on = 1;
    // basic accumulation, no dither
    tag = "R2"; en = 1; fcw = 32'h0123_4567;
    cyc(20);
    // wrap with large tuning word
    fcw = 32'hF000_0001;
    cyc(12);
    // modulation offsets
    tag = "R5"; fcw = 32'h0100_0000; freq_off = 32'hFF80_0000; phase_off = 32'h8000_0000;
    cyc(10);
    phase_off = 32'h0007_FFFF;
    cyc(6);
    // enable toggling
    tag = "R3";
    for (int i = 0; i < 8; i++) begin en = i[0]; cyc(2); end
    en = 0; rec = phase_out; cyc(3);
    check("R3 hold phase_out", phase_out, rec);
    // preset while disabled and enabled
    tag = "R4"; preset_val = 32'hDEAD_BEEF; preset_en = 1; cyc(1);
    check("R4 preset en low", phase_out, 32'hDEAD_BEEF);
    preset_en = 0; en = 1; cyc(3);
    preset_val = 32'h7FFF_FFF0; preset_en = 1; cyc(1);
    check("R4 preset en high", phase_out, 32'h7FFF_FFF0);
    preset_en = 0; cyc(3);
    // dither on
    tag = "R7"; dither_en = 1; phase_off = 0; fcw = 32'h0010_0000; freq_off = 0;
    cyc(40);
    en = 0; cyc(3); en = 1; cyc(10);
    // dither off: plain truncation of the phase that was visible
    tag = "R8"; dither_en = 0;
    cyc(1);
    for (int i = 0; i < 5; i++) begin
      rec = phase_out; cyc(1);
      check("R8 plain truncation", 32'(addr_i), 32'(rec[31:20]));
    end
    dither_en = 1; cyc(20);
    chk_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule